// File: doc/BRIEF.md
# Flash Embedded-Operation Toggle Status Generator

This block sits on the read path of a flash device. It produces the two toggle status bits that a host polls while an embedded program or erase runs inside the device. The command decoder supplies the current operation mode and a mask of the sectors that are queued for erasure. The block then decides, on every read strobe, whether each toggle bit inverts. While any operation is in flight, the read bus carries a status word in place of array data.

Bit 6 tells the host whether an operation is actively running: it inverts during program, erase and suspend-program, and holds during a plain erase suspend. Bit 2 tells the host which sectors are involved: it inverts only for reads that land in a sector marked for erasure, and it carries no information about suspension. A program aimed at a protected sector opens a short guard window of a configurable number of cycles. During that window bit 6 toggles, and after it the block returns array data. The read strobe is a single-cycle pulse, so the decoder can derive it from output-enable, chip-enable or an address-valid edge.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset, status_active_o is low, rd_data_o equals array_data_i, and both toggle bits are 0.
- R2: In program mode (op_mode_i = 1) and erase mode (2), bit 6 of the status word inverts after every cycle in which rd_strobe_i is high.
- R3: In erase (2), erase-suspend (3) and suspend-program (4) modes, bit 2 inverts after a read strobe whose rd_sector_i selects a set bit of erase_mask_i (mask bit n belongs to sector n).
- R4: In erase-suspend mode (3), with no guard window open, bit 6 keeps its value across read strobes.
- R5: Bit 2 keeps its value after a read strobe to a sector whose mask bit is clear, and after any read strobe in program mode.
- R6: In suspend-program mode (4), bit 6 inverts on every read strobe. Once the mode returns to erase-suspend, bit 6 stops inverting.
- R7: A prot_start_i pulse while the mode is idle makes status_active_o high for exactly PROT_CYCLES cycles, starting in the next cycle. Bit 6 inverts on read strobes during that time, and rd_data_o returns to array data afterwards.
- R8: A prot_start_i pulse while the mode is not idle is ignored: no guard window opens.
- R9: While busy, rd_data_o carries bit 6 at position 6 and bit 2 at position 2, with every other bit 0. While not busy, rd_data_o equals array_data_i and both toggle bits are cleared, so the next operation starts from 0. Mode codes 0 and 5 to 7 count as idle.
- R10: In cycles without a read strobe, neither toggle bit changes while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode_i | input | 3 | Operation mode code from the command decoder |
| erase_mask_i | input | SECTORS | One bit per sector selected for erasure |
| prot_start_i | input | 1 | Pulse: program command aimed at a protected sector |
| rd_strobe_i | input | 1 | Single-cycle read-cycle marker |
| rd_sector_i | input | SEC_W | Sector index of the read address |
| array_data_i | input | DATA_W | Data from the flash array |
| rd_data_o | output | DATA_W | Read data: status word while busy, array data otherwise |
| status_active_o | output | 1 | High while the status word replaces array data |

## Verification
The assertions assume that rd_strobe_i is a pulse sampled on the clock, and that op_mode_i and erase_mask_i change only between read strobes. They also assume that prot_start_i arrives as a one-cycle pulse. The stimulus drives every input at the falling clock edge. It holds the mode and mask for several strobes at a time, and it issues the protected-program pulse for one cycle only. The pulse is sent both while the mode is idle and while a program is running.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE     = 3'd2,
    OP_SUSP      = 3'd3,
    OP_SUSP_PROG = 3'd4
  } op_mode_e;

  // Modes in which an embedded algorithm is actively running
  function automatic logic runs_active(input logic [2:0] m);
    return (m == OP_PROG) || (m == OP_ERASE) || (m == OP_SUSP_PROG);
  endfunction

  // Modes in which an erase sector selection is meaningful
  function automatic logic erase_context(input logic [2:0] m);
    return (m == OP_ERASE) || (m == OP_SUSP) || (m == OP_SUSP_PROG);
  endfunction

  function automatic logic mode_busy(input logic [2:0] m);
    return runs_active(m) || erase_context(m);
  endfunction

  // Status byte: bit 6 activity toggle, bit 2 sector toggle
  function automatic logic [7:0] status_byte(input logic b6, input logic b2);
    logic [7:0] s;
    s    = 8'h00;
    s[6] = b6;
    s[2] = b2;
    return s;
  endfunction

endpackage

// File: rtl/fts_guard_timer.sv
module fts_guard_timer #(
  parameter int CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain_q <= '0;
    else if (start_i)          remain_q <= LOAD;
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign active_o = (remain_q != '0);

  a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q <= LOAD);
  a_r7_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o);
  a_r7_no_spurious_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !start_i) |=> !active_o);
endmodule

// File: rtl/fts_sector_hit.sv
module fts_sector_hit #(
  parameter int SECTORS = 8,
  localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic [SECTORS-1:0] mask_i,
  input  logic [SEC_W-1:0]   sector_i,
  output logic               hit_o
);
  logic [SECTORS-1:0] match;

  for (genvar g = 0; g < SECTORS; g++) begin : g_sec
    assign match[g] = mask_i[g] && (sector_i == SEC_W'(g));
  end

  assign hit_o = |match;

  always_comb begin
    a_r3_single_match: assert ($onehot0(match));
  end
endmodule

// File: rtl/fts_toggle_flop.sv
module fts_toggle_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= 1'b0;
    else if (clear_i) q <= 1'b0;
    else if (step_i)  q <= ~q;
  end

  assign q_o = q;

  a_r10_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> $stable(q_o));
  a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !q_o);
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
  import fts_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SECTORS     = 8,
  parameter int PROT_CYCLES = 250,
  localparam int SEC_W      = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_mode_i,
  input  logic [SECTORS-1:0] erase_mask_i,
  input  logic               prot_start_i,
  input  logic               rd_strobe_i,
  input  logic [SEC_W-1:0]   rd_sector_i,
  input  logic [DATA_W-1:0]  array_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               status_active_o
);
  localparam int STAT_W = (DATA_W < 8) ? DATA_W : 8;

  // Named internal events
  logic mode_idle;
  logic guard_start;
  logic guard_active;
  logic sector_hit;
  logic busy;
  logic step_b6;
  logic step_b2;
  logic bit6_q;
  logic bit2_q;
  logic [7:0] stat_byte;

  assign mode_idle   = !mode_busy(op_mode_i);
  assign guard_start = prot_start_i && mode_idle;

  fts_guard_timer #(.CYCLES(PROT_CYCLES)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (guard_start),
    .active_o (guard_active)
  );

  fts_sector_hit #(.SECTORS(SECTORS)) u_hit (
    .mask_i   (erase_mask_i),
    .sector_i (rd_sector_i),
    .hit_o    (sector_hit)
  );

  assign busy    = !mode_idle || guard_active;
  assign step_b6 = rd_strobe_i && (runs_active(op_mode_i) || guard_active);
  assign step_b2 = rd_strobe_i && erase_context(op_mode_i) && sector_hit;

  fts_toggle_flop u_b6 (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (!busy),
    .step_i  (step_b6),
    .q_o     (bit6_q)
  );

  fts_toggle_flop u_b2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (!busy),
    .step_i  (step_b2),
    .q_o     (bit2_q)
  );

  assign stat_byte = status_byte(bit6_q, bit2_q);

  always_comb begin
    rd_data_o = array_data_i;
    if (busy) begin
      rd_data_o = '0;
      rd_data_o[STAT_W-1:0] = stat_byte[STAT_W-1:0];
    end
  end

  assign status_active_o = busy;

  a_r2_b6_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && busy && (op_mode_i == OP_PROG || op_mode_i == OP_ERASE))
      |=> (bit6_q != $past(bit6_q)));
  a_r4_b6_frozen_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode_i == OP_SUSP && !guard_active) |=> $stable(bit6_q));
  a_r5_b2_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (!sector_hit || op_mode_i == OP_PROG)) |=> $stable(bit2_q));
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_start_i && !mode_idle && !guard_active) |=> !guard_active);
  a_r9_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !status_active_o |-> (rd_data_o == array_data_i));
endmodule

// File: tb/flash_toggle_status_tb_top.sv
`timescale 1ns/1ps
module flash_toggle_status_tb_top;
  localparam int DW   = 32;
  localparam int NSEC = 8;
  localparam int PROT = 250;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_mode_i = 3'd0;
  logic [NSEC-1:0] erase_mask_i = '0;
  logic          prot_start_i = 1'b0;
  logic          rd_strobe_i = 1'b0;
  logic [2:0]    rd_sector_i = '0;
  logic [DW-1:0] array_data_i = 32'hA5C3_1E7F;
  logic [DW-1:0] rd_data_o;
  logic          status_active_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m6 = 0, m2 = 0, mcnt = 0;

  always #2 clk = ~clk;

  flash_toggle_status #(.DATA_W(DW), .SECTORS(NSEC), .PROT_CYCLES(PROT)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_mode_i(op_mode_i), .erase_mask_i(erase_mask_i),
    .prot_start_i(prot_start_i), .rd_strobe_i(rd_strobe_i), .rd_sector_i(rd_sector_i),
    .array_data_i(array_data_i), .rd_data_o(rd_data_o), .status_active_o(status_active_o));

  function automatic bit model_busy();
    return (op_mode_i >= 1 && op_mode_i <= 4) || (mcnt != 0);
  endfunction

  task automatic check(input string tag);
    logic [DW-1:0] exp_d;
    bit exp_b;
    exp_b = model_busy();
    exp_d = exp_b ? (DW'(m6) << 6) | (DW'(m2) << 2) : array_data_i;
    total++;
    if (rd_data_o !== exp_d || status_active_o !== exp_b) begin
      bad++;
      $display("FAIL %s: data=%h active=%b expected data=%h active=%b",
               tag, rd_data_o, status_active_o, exp_d, exp_b);
    end
  endtask

  // one cycle: drive, check, advance model across the edge
  task automatic step(input string tag, input logic [2:0] md, input bit rd,
                      input int sec, input bit ps);
    int n6, n2, ncnt;
    bit idle_md, act, ectx, hit;
    op_mode_i = md; rd_strobe_i = rd; rd_sector_i = 3'(sec); prot_start_i = ps;
    array_data_i = array_data_i ^ 32'h0101_0101;
    #1;
    check(tag);
    idle_md = !(md >= 1 && md <= 4);
    act  = (md == 1 || md == 2 || md == 4);
    ectx = (md == 2 || md == 3 || md == 4);
    hit  = erase_mask_i[sec];
    if (ps && idle_md) ncnt = PROT;
    else if (mcnt > 0) ncnt = mcnt - 1;
    else ncnt = 0;
    if (!model_busy()) begin n6 = 0; n2 = 0; end
    else begin
      n6 = (rd && (act || mcnt != 0)) ? 1 - m6 : m6;
      n2 = (rd && ectx && hit) ? 1 - m2 : m2;
    end
    @(posedge clk);
    m6 = n6; m2 = n2; mcnt = ncnt;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1");
    @(negedge clk);

    // R2 program mode: bit 6 flips per read, R5 bit 2 unaffected
    erase_mask_i = 8'b0000_0100;
    for (int i = 0; i < 6; i++) step("R2", 3'd1, 1'b1, 2, 1'b0);
    step("R10", 3'd1, 1'b0, 2, 1'b0);
    step("R10", 3'd1, 1'b0, 2, 1'b0);
    step("R5", 3'd1, 1'b1, 2, 1'b0);
    // R8 protected start while programming is ignored
    step("R8", 3'd1, 1'b0, 0, 1'b1);
    step("R9", 3'd0, 1'b0, 0, 1'b0);
    step("R9", 3'd0, 1'b1, 0, 1'b0);

    // R3 erase: hit and miss sectors
    erase_mask_i = 8'b1001_0010;
    for (int i = 0; i < 3; i++) step("R3", 3'd2, 1'b1, 1, 1'b0);
    for (int i = 0; i < 3; i++) step("R5", 3'd2, 1'b1, 2, 1'b0);
    for (int i = 0; i < 3; i++) step("R3", 3'd2, 1'b1, 7, 1'b0);
    step("R10", 3'd2, 1'b0, 7, 1'b0);

    // R4 suspend: bit 6 frozen, bit 2 toggles on hit
    for (int i = 0; i < 4; i++) step("R4", 3'd3, 1'b1, 4, 1'b0);
    step("R5", 3'd3, 1'b1, 5, 1'b0);

    // R6 suspend-program then back to suspend
    for (int i = 0; i < 5; i++) step("R6", 3'd4, 1'b1, 1, 1'b0);
    for (int i = 0; i < 3; i++) step("R6", 3'd3, 1'b1, 0, 1'b0);

    // R9 return to idle, unused codes idle
    step("R9", 3'd0, 1'b1, 1, 1'b0);
    step("R9", 3'd6, 1'b1, 1, 1'b0);
    step("R9", 3'd7, 1'b0, 1, 1'b0);
    step("R9", 3'd2, 1'b0, 1, 1'b0);

    // R7 protected-sector window
    step("R7", 3'd0, 1'b0, 0, 1'b1);
    for (int i = 0; i < PROT + 4; i++) step("R7", 3'd0, (i % 3) == 0, 0, 1'b0);

    step("R7", 3'd5, 1'b1, 0, 1'b1);
    for (int i = 0; i < 6; i++) step("R7", 3'd0, 1'b1, 3, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule